// File: doc/BRIEF.md
# Three-phase carrier PWM timer

This block produces three positive-phase PWM signals, one per motor phase, from a single carrier counter that all three phases share. The carrier is either triangular, counting up to a period value and back down again, or sawtooth, counting up and wrapping to zero. Each phase compares the carrier against a width value and is driven high while the count is below it. In triangular mode the pulse is therefore centred on the carrier valley. A dual-width option gives each phase one width for the rising half of the triangle and another for the falling half. The three outputs feed a separate dead-time and complementary-output stage.

The counter advances on a tick that comes from a free-running prescaler, at the full clock rate or divided by 2, 8 or 32, or from an external slow tick enable. The period, the widths, the carrier shape, the dual-width option and the per-phase force controls are sampled only at the carrier boundary. Changing them therefore never cuts a carrier cycle short or splits a pulse. A force control can hold a phase at a fixed level for whole carrier cycles. An interrupt pulse is raised at every Nth carrier boundary, with N selectable up to 15.

Top module: `tri_phase_pwm`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all phase outputs and the interrupt are low.
- R2: In triangular mode (saw_mode=0), one carrier cycle lasts 2*(m+1) ticks, where m is the period value. The count rises from 0 to m, holds m for a second tick, then falls back to 0.
- R3: In sawtooth mode (saw_mode=1), one carrier cycle lasts m+1 ticks, with the count running 0..m and then wrapping.
- R4: A phase is high while the count is below its width n. Per carrier cycle this gives 2*min(n,m+1) ticks in triangular mode and min(n,m+1) ticks in sawtooth mode. Phase k uses bits [16k+15:16k] of a width bus.
- R5: In triangular mode with dual_width=1, each phase uses width_rise while counting up and width_fall while counting down. This gives min(rise,m+1)+min(fall,m+1) high ticks per cycle.
- R6: tick_sel selects the count tick: 0 is every clock, 1 is every 2nd clock, 2 is every 8th, 3 is every 32nd, and 4 to 7 use ext_tick. The count never moves between ticks.
- R7: Period, widths, carrier shape, dual_width and the force controls are taken only at a carrier boundary. The cycle in progress keeps its old values.
- R8: When force_en[k] is set, phase k is held at force_lvl[k] for every carrier cycle that starts while the bit is set.
- R9: carrier_irq is a one-clock pulse that follows every Nth carrier boundary, where N=irq_every and a value of 0 acts as 1.
- R10: A pulse on irq_every_wr clears the boundary count, so the next interrupt comes N boundaries after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | External slow tick enable, used when tick_sel is 4 to 7 |
| tick_sel | input | 3 | Count tick select |
| saw_mode | input | 1 | 1 for sawtooth carrier, 0 for triangular |
| dual_width | input | 1 | Separate widths per triangle half |
| period | input | 16 | Carrier period value m |
| width_rise | input | 48 | Per-phase width (rising half in dual mode) |
| width_fall | input | 48 | Per-phase width for the falling half |
| force_en | input | 3 | Per-phase force enable |
| force_lvl | input | 3 | Per-phase forced level |
| irq_every | input | 4 | Interrupt decimation N |
| irq_every_wr | input | 1 | Pulse when irq_every is rewritten; clears the decimation count |
| phase_out | output | 3 | Registered positive-phase outputs |
| carrier_irq | output | 1 | Decimated carrier interrupt pulse |

## Verification
The hardest situations to reach are a setting that changes in the middle of a carrier cycle, and a decimation clear that lands part-way through a count of boundaries. Both depend on where the hidden carrier count stands when the change arrives. The stimulus uses the interrupt pulse as a phase marker. It waits for an interrupt, then rewrites the period, or waits a fixed number of clocks before pulsing irq_every_wr. It then measures the clocks to the next interrupts. A behavioural model runs beside the design and compares every output on every clock, including while settings change and while the tick source is switched.

// File: rtl/tpp_pkg.sv
package tpp_pkg;
  typedef enum logic [2:0] {
    TS_FULL   = 3'd0,
    TS_HALF   = 3'd1,
    TS_EIGHTH = 3'd2,
    TS_32ND   = 3'd3,
    TS_EXT    = 3'd4
  } tick_sel_e;
endpackage

// File: rtl/tpp_prescaler.sv
module tpp_prescaler #(
  parameter int DIV_LOG = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_tick,
  input  logic [2:0] sel,
  output logic       tick
);
  import tpp_pkg::*;

  logic [DIV_LOG-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) pre <= '0;
    else     pre <= pre + 1'b1;
  end

  always_comb begin
    case (sel)
      TS_FULL:   tick = 1'b1;
      TS_HALF:   tick = pre[0];
      TS_EIGHTH: tick = &pre[2:0];
      TS_32ND:   tick = &pre;
      default:   tick = ext_tick;
    endcase
  end
endmodule

// File: rtl/tpp_carrier.sv
module tpp_carrier #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          saw_in,
  input  logic          dual_in,
  input  logic [CW-1:0] per_in,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] per_q,
  output logic          up,
  output logic          saw_q,
  output logic          dual_q,
  output logic          bnd
);
  logic at_end;

  always_comb at_end = saw_q ? (cnt == per_q) : (!up && cnt == '0);
  assign bnd = tick && at_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      up     <= 1'b1;
      per_q  <= '0;
      saw_q  <= 1'b0;
      dual_q <= 1'b0;
    end else if (bnd) begin
      cnt    <= '0;
      up     <= 1'b1;
      per_q  <= per_in;
      saw_q  <= saw_in;
      dual_q <= dual_in;
    end else if (tick) begin
      if (saw_q)              cnt <= cnt + 1'b1;
      else if (up) begin
        if (cnt == per_q)     up  <= 1'b0;
        else                  cnt <= cnt + 1'b1;
      end else                cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tpp_phase.sv
module tpp_phase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bnd,
  input  logic          up,
  input  logic          saw_q,
  input  logic          dual_q,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] w_rise,
  input  logic [CW-1:0] w_fall,
  input  logic          frc_en,
  input  logic          frc_lvl,
  output logic          fe_q,
  output logic          fl_q,
  output logic          pout
);
  logic [CW-1:0] wr_q, wf_q, thr;

  always_comb thr = (!saw_q && dual_q && !up) ? wf_q : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q <= '0;
      wf_q <= '0;
      fe_q <= 1'b0;
      fl_q <= 1'b0;
      pout <= 1'b0;
    end else begin
      pout <= fe_q ? fl_q : (cnt < thr);
      if (bnd) begin
        wr_q <= w_rise;
        wf_q <= w_fall;
        fe_q <= frc_en;
        fl_q <= frc_lvl;
      end
    end
  end
endmodule

// File: rtl/tpp_irq_decim.sv
module tpp_irq_decim #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bnd,
  input  logic [DW-1:0] every,
  input  logic          every_wr,
  output logic [DW-1:0] dcnt,
  output logic          irq
);
  logic [DW-1:0] nthr;
  logic          hit;

  always_comb begin
    nthr = (every == '0) ? {{(DW-1){1'b0}}, 1'b1} : every;
    hit  = bnd && (({1'b0, dcnt} + 1'b1) >= {1'b0, nthr});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt <= '0;
      irq  <= 1'b0;
    end else begin
      irq <= hit;
      if (every_wr)  dcnt <= '0;
      else if (bnd)  dcnt <= hit ? '0 : dcnt + 1'b1;
    end
  end
endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm #(
  parameter int CW  = 16,
  parameter int NPH = 3,
  parameter int DW  = 4,
  parameter int DIV_LOG = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_tick,
  input  logic [2:0]        tick_sel,
  input  logic              saw_mode,
  input  logic              dual_width,
  input  logic [CW-1:0]     period,
  input  logic [NPH*CW-1:0] width_rise,
  input  logic [NPH*CW-1:0] width_fall,
  input  logic [NPH-1:0]    force_en,
  input  logic [NPH-1:0]    force_lvl,
  input  logic [DW-1:0]     irq_every,
  input  logic              irq_every_wr,
  output logic [NPH-1:0]    phase_out,
  output logic              carrier_irq
);
  logic          tick, bnd, up, saw_q, dual_q;
  logic [CW-1:0] cnt, per_q;
  logic [DW-1:0] dcnt;
  logic [NPH-1:0] frc_en_q, frc_lvl_q;

  tpp_prescaler #(.DIV_LOG(DIV_LOG)) u_pre (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .sel(tick_sel), .tick(tick)
  );

  tpp_carrier #(.CW(CW)) u_car (
    .clk(clk), .rst(rst), .tick(tick), .saw_in(saw_mode), .dual_in(dual_width),
    .per_in(period), .cnt(cnt), .per_q(per_q), .up(up), .saw_q(saw_q),
    .dual_q(dual_q), .bnd(bnd)
  );

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    tpp_phase #(.CW(CW)) u_ph (
      .clk(clk), .rst(rst), .bnd(bnd), .up(up), .saw_q(saw_q), .dual_q(dual_q),
      .cnt(cnt), .w_rise(width_rise[k*CW +: CW]), .w_fall(width_fall[k*CW +: CW]),
      .frc_en(force_en[k]), .frc_lvl(force_lvl[k]),
      .fe_q(frc_en_q[k]), .fl_q(frc_lvl_q[k]), .pout(phase_out[k])
    );
  end

  tpp_irq_decim #(.DW(DW)) u_irq (
    .clk(clk), .rst(rst), .bnd(bnd), .every(irq_every), .every_wr(irq_every_wr),
    .dcnt(dcnt), .irq(carrier_irq)
  );
endmodule

// File: rtl/tpp_checker.sv
module tpp_checker #(
  parameter int CW  = 16,
  parameter int NPH = 3,
  parameter int DW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           tick,
  input logic           bnd,
  input logic [CW-1:0]  cnt,
  input logic [CW-1:0]  per_q,
  input logic [DW-1:0]  dcnt,
  input logic           irq_every_wr,
  input logic           carrier_irq,
  input logic [NPH-1:0] frc_en_q,
  input logic [NPH-1:0] frc_lvl_q,
  input logic [NPH-1:0] phase_out
);
  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (rst)
    cnt <= per_q);

  assert_count_only_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  assert_period_held_R7: assert property (@(posedge clk) disable iff (rst)
    !bnd |=> $stable(per_q));

  assert_irq_follows_bnd_R9: assert property (@(posedge clk) disable iff (rst)
    carrier_irq |-> $past(bnd));

  assert_decim_range_R9: assert property (@(posedge clk) disable iff (rst)
    dcnt <= DW'(14));

  assert_wr_clears_R10: assert property (@(posedge clk) disable iff (rst)
    irq_every_wr |=> dcnt == '0);

  for (genvar k = 0; k < NPH; k++) begin : g_frc
    assert_forced_level_R8: assert property (@(posedge clk) disable iff (rst)
      frc_en_q[k] |=> phase_out[k] == $past(frc_lvl_q[k]));
  end
endmodule

bind tri_phase_pwm tpp_checker #(.CW(CW), .NPH(NPH), .DW(DW)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .bnd(bnd), .cnt(cnt), .per_q(per_q),
  .dcnt(dcnt), .irq_every_wr(irq_every_wr), .carrier_irq(carrier_irq),
  .frc_en_q(frc_en_q), .frc_lvl_q(frc_lvl_q), .phase_out(phase_out)
);

// File: tb/tri_phase_pwm_tb_top.sv
`timescale 1ns/1ps
module tri_phase_pwm_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_tick = 1'b0;
  logic [2:0]  tick_sel = 3'd0;
  logic        saw_mode = 1'b0;
  logic        dual_width = 1'b0;
  logic [15:0] period = 16'd0;
  logic [47:0] width_rise = '0;
  logic [47:0] width_fall = '0;
  logic [2:0]  force_en = '0;
  logic [2:0]  force_lvl = '0;
  logic [3:0]  irq_every = 4'd1;
  logic        irq_every_wr = 1'b0;
  logic [2:0]  phase_out;
  logic        carrier_irq;

  int nchk = 0;
  int nfail = 0;

  always #5 clk = ~clk;

  tri_phase_pwm dut_i (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .tick_sel(tick_sel),
    .saw_mode(saw_mode), .dual_width(dual_width), .period(period),
    .width_rise(width_rise), .width_fall(width_fall), .force_en(force_en),
    .force_lvl(force_lvl), .irq_every(irq_every), .irq_every_wr(irq_every_wr),
    .phase_out(phase_out), .carrier_irq(carrier_irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // external slow tick: one pulse every third clock
  int ecnt = 0;
  always @(negedge clk) begin
    ecnt = (ecnt + 1) % 3;
    ext_tick <= (ecnt == 0);
  end

  // behavioural reference model
  int r_pre, r_cnt, r_per, r_dcnt, nth, thr;
  bit r_up, r_saw, r_dual, tk, bd, hit;
  int r_wu[3], r_wd[3];
  bit r_fe[3], r_fl[3];
  logic [2:0] r_out = '0;
  logic r_irq = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      r_pre = 0; r_cnt = 0; r_per = 0; r_dcnt = 0;
      r_up = 1; r_saw = 0; r_dual = 0;
      r_out = '0; r_irq = 0;
      for (int i = 0; i < 3; i++) begin
        r_wu[i] = 0; r_wd[i] = 0; r_fe[i] = 0; r_fl[i] = 0;
      end
    end else begin
      case (tick_sel)
        3'd0: tk = 1;
        3'd1: tk = (r_pre % 2 == 1);
        3'd2: tk = (r_pre % 8 == 7);
        3'd3: tk = (r_pre == 31);
        default: tk = ext_tick;
      endcase
      if (r_saw) bd = tk && (r_cnt == r_per);
      else       bd = tk && !r_up && (r_cnt == 0);
      for (int i = 0; i < 3; i++) begin
        thr = (!r_saw && r_dual && !r_up) ? r_wd[i] : r_wu[i];
        r_out[i] = r_fe[i] ? r_fl[i] : (r_cnt < thr);
      end
      nth = (irq_every == 0) ? 1 : int'(irq_every);
      hit = bd && (r_dcnt + 1 >= nth);
      r_irq = hit;
      if (irq_every_wr) r_dcnt = 0;
      else if (bd)      r_dcnt = hit ? 0 : r_dcnt + 1;
      if (bd) begin
        r_cnt = 0; r_up = 1; r_per = int'(period);
        r_saw = saw_mode; r_dual = dual_width;
        for (int i = 0; i < 3; i++) begin
          r_wu[i] = int'(width_rise[i*16 +: 16]);
          r_wd[i] = int'(width_fall[i*16 +: 16]);
          r_fe[i] = force_en[i]; r_fl[i] = force_lvl[i];
        end
      end else if (tk) begin
        if (r_saw) r_cnt = r_cnt + 1;
        else if (r_up) begin
          if (r_cnt == r_per) r_up = 0;
          else r_cnt = r_cnt + 1;
        end else r_cnt = r_cnt - 1;
      end
      r_pre = (r_pre + 1) % 32;
    end
  end

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 3; i++)
        chk(phase_out[i] === r_out[i],
            r_fe[i] ? "R8 phase" : (r_saw ? "R3 phase" : "R2 phase"),
            int'(phase_out[i]), int'(r_out[i]));
      chk(carrier_irq === r_irq, "R9 irq", int'(carrier_irq), int'(r_irq));
    end
  end

  task automatic wait_irq();
    do @(negedge clk); while (!carrier_irq);
  endtask

  task automatic gap(output int g);
    g = 0;
    do begin @(negedge clk); g++; end while (!carrier_irq);
  endtask

  task automatic settle();
    wait_irq(); wait_irq(); wait_irq();
  endtask

  task automatic highs(input int n, output int h0, output int h1, output int h2);
    h0 = 0; h1 = 0; h2 = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      h0 += int'(phase_out[0]); h1 += int'(phase_out[1]); h2 += int'(phase_out[2]);
    end
  endtask

  task automatic setup(input bit saw, input bit dual, input int per, input int sel);
    @(negedge clk);
    saw_mode = saw; dual_width = dual; period = 16'(per); tick_sel = 3'(sel);
    settle();
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : stim
    int g, h0, h1, h2;
    repeat (4) @(negedge clk);
    chk(phase_out == 3'b000, "R1 outputs in reset", int'(phase_out), 0);
    chk(carrier_irq == 1'b0, "R1 irq in reset", int'(carrier_irq), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(phase_out == 3'b000 && carrier_irq == 1'b0, "R1 after release",
        int'({carrier_irq, phase_out}), 0);

    width_rise = {16'd4, 16'd3, 16'd2};
    width_fall = {16'd12, 16'd1, 16'd5};

    // triangular
    setup(0, 0, 5, 0);
    gap(g); chk(g == 12, "R2 triangular period", g, 12);
    highs(12, h0, h1, h2);
    chk(h0 == 4 && h1 == 6 && h2 == 8, "R4 triangular widths", h0*100 + h1*10 + h2, 468);

    // sawtooth
    setup(1, 0, 9, 0);
    gap(g); chk(g == 10, "R3 sawtooth period", g, 10);
    highs(10, h0, h1, h2);
    chk(h0 == 2 && h1 == 3 && h2 == 4, "R4 sawtooth widths", h0*100 + h1*10 + h2, 234);

    // dual widths, one capped at m+1
    @(negedge clk); width_rise = {16'd3, 16'd3, 16'd2};
    setup(0, 1, 9, 0);
    highs(20, h0, h1, h2);
    chk(h0 == 7, "R5 dual phase0", h0, 7);
    chk(h1 == 4, "R5 dual phase1", h1, 4);
    chk(h2 == 13, "R5 dual phase2 capped", h2, 13);

    // tick sources
    setup(0, 0, 3, 1);
    gap(g); chk(g == 16, "R6 divide by 2", g, 16);
    setup(1, 0, 3, 2);
    gap(g); chk(g == 32, "R6 divide by 8", g, 32);
    setup(1, 0, 1, 3);
    gap(g); chk(g == 64, "R6 divide by 32", g, 64);
    setup(1, 0, 1, 4);
    gap(g); chk(g == 6, "R6 external tick", g, 6);

    // force
    @(negedge clk); width_rise = {16'd4, 16'd3, 16'd2};
    force_en = 3'b011; force_lvl = 3'b010;
    setup(1, 0, 9, 0);
    highs(10, h0, h1, h2);
    chk(h0 == 0, "R8 forced low", h0, 0);
    chk(h1 == 10, "R8 forced high", h1, 10);
    chk(h2 == 4, "R8 unforced phase", h2, 4);
    @(negedge clk); force_en = 3'b000;

    // shadowing of the period
    settle();
    period = 16'd3;
    gap(g); chk(g == 10, "R7 old period kept", g, 10);
    gap(g); chk(g == 4, "R7 new period applied", g, 4);

    // decimation
    @(negedge clk); period = 16'd1; irq_every = 4'd3;
    settle();
    gap(g); chk(g == 6, "R9 every third boundary", g, 6);
    @(negedge clk); irq_every = 4'd0;
    settle();
    gap(g); chk(g == 2, "R9 zero acts as one", g, 2);

    // clearing the decimation count
    @(negedge clk); irq_every = 4'd15;
    settle();
    repeat (10) @(negedge clk);
    irq_every_wr = 1'b1;
    @(negedge clk);
    irq_every_wr = 1'b0;
    gap(g); chk(g >= 28 && g <= 32, "R10 count restarted", g, 30);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule